// File: doc/BRIEF.md
# Unaligned Quad-Word Load Realigner

This block lets a core read four consecutive 32-bit words that start at any word address, even though memory can return only quad-aligned groups of four words. Aligned quads arrive one after another on a valid/ready input. The block holds at most two of them: the older and the newer. Each output quad is cut from the eight words those two entries hold, starting at a word offset between 0 and 3. The result leaves on a valid/ready output.

The offset is taken from `start_ofs` on the first beat accepted after reset or after a flush. It then stays fixed for the rest of the stream. With offset 0 each quad passes straight through. With any other offset the first result has to wait for two aligned quads. After that, every new aligned quad produces one merged quad and retires the older entry, so a sequential unaligned stream such as a filter delay line runs at one quad per cycle. A `flush` pulse drops everything held and re-arms the offset capture. Address generation and memory timing belong to the surrounding logic.

Top module: `quad_realign_buf`

## Requirements
- R1: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Word k of a quad, for k from 0 to 3, sits in bits [32k+31:32k], so the lowest address is in bits [31:0]. This applies to both `in_quad` and `out_quad`.
- R3: With offset 0, a quad accepted into an empty buffer appears unchanged on `out_quad` with `out_valid` high in the next cycle.
- R4: With offset o not equal to 0, `out_valid` stays low until two quads are held. Output word k is word o+k of the eight-word sequence formed by the older entry (words 0 to 3) followed by the newer entry (words 4 to 7).
- R5: `start_ofs` is captured on the first accepted beat after reset or flush. It is ignored at all other times, until the next flush.
- R6: With input always valid and `out_ready` always high, the input is never stalled. An offset-0 stream of N quads yields N outputs. A stream with a nonzero offset yields N-1 outputs, and once the first output appears there is one per cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_quad` stays constant. When two quads are held and no output is taken, `in_ready` is 0.
- R8: While `flush` is high, `out_valid` and `in_ready` are 0. A flush discards every held entry and any beat offered in the same cycle, and the next stream captures a new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop held entries and re-arm offset capture |
| start_ofs | input | 2 | Word offset of the stream, taken on its first beat |
| in_valid | input | 1 | Aligned quad present |
| in_ready | output | 1 | Aligned quad taken this cycle if valid |
| in_quad | input | 128 | Aligned quad, lowest word in bits [31:0] |
| out_valid | output | 1 | Merged quad present |
| out_ready | input | 1 | Consumer takes the merged quad |
| out_quad | output | 128 | Merged quad, lowest word in bits [31:0] |

## Verification
The hardest situation to reach is the full buffer with a nonzero offset, where a pop and a push must happen in the same cycle. If the shift and the refill do not line up exactly, the result is a skipped or a repeated word.

The bench reaches this case by streaming quads whose words carry their own addresses. Every output can therefore be predicted from the offset and the output index alone. Two further tests stall the consumer until both entries are full and then release it, and issue a flush while a leftover entry is still held and a new beat is offered at the same time.

// File: rtl/quad_realign_buf.sv
module quad_realign_buf #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  localparam int OFS_W = $clog2(LANES),
  localparam int QW    = WORD_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [QW-1:0]    in_quad,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW-1:0]    out_quad
);

  logic [1:0]       cnt;
  logic             primed;
  logic [OFS_W-1:0] ofs_q;
  logic [QW-1:0]    ent0, ent1;
  logic [2*QW-1:0]  pair;
  logic             push, pop, need_pair;

  assign need_pair = (ofs_q != '0);
  assign out_valid = !flush && (need_pair ? (cnt == 2'd2) : (cnt != 2'd0));
  assign pop       = out_valid && out_ready;
  assign in_ready  = !flush && ((cnt != 2'd2) || pop);
  assign push      = in_valid && in_ready;
  assign pair      = {ent1, ent0};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFS_W:0] idx;
    assign idx = {1'b0, ofs_q} + (OFS_W+1)'(k);
    assign out_quad[k*WORD_W +: WORD_W] = pair[idx*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
      ofs_q  <= '0;
      ent0   <= '0;
      ent1   <= '0;
    end else if (flush) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else begin
      if (push && !primed) begin
        primed <= 1'b1;
        ofs_q  <= start_ofs;
      end
      unique case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) ent0 <= in_quad;
          else             ent1 <= in_quad;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          ent0 <= ent1;
          cnt  <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd2) begin
            ent0 <= ent1;
            ent1 <= in_quad;
          end else begin
            ent0 <= in_quad;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/quad_realign_buf_chk.sv
module quad_realign_buf_chk #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  localparam int OFS_W = $clog2(LANES),
  localparam int QW    = WORD_W * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [OFS_W-1:0] start_ofs,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [QW-1:0]    out_quad,
  input logic [1:0]       cnt,
  input logic [OFS_W-1:0] ofs_q,
  input logic             primed
);

  logic acc;
  assign acc = in_valid && in_ready;

  assert_bounded_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (flush || (out_valid && $stable(out_quad))));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  assert_pair_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ofs_q != '0) |-> (cnt == 2'd2));

  assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2 && out_ready && !flush) |-> in_ready);

  assert_offset_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !flush) |=> $stable(ofs_q));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnt == 2'd0 && ((primed && ofs_q == '0) || (!primed && start_ofs == '0)))
      |=> (out_valid || flush));

endmodule

bind quad_realign_buf quad_realign_buf_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .start_ofs(start_ofs),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_quad(out_quad), .cnt(cnt), .ofs_q(ofs_q),
  .primed(primed)
);

// File: tb/quad_realign_buf_bench.sv
`timescale 1ns/1ps
module quad_realign_buf_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [1:0]   start_ofs = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_quad = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_quad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_realign_buf u_quad_realign_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start_ofs(start_ofs),
    .in_valid(in_valid), .in_ready(in_ready), .in_quad(in_quad),
    .out_valid(out_valid), .out_ready(out_ready), .out_quad(out_quad)
  );

  function automatic logic [127:0] mk(input int addr);
    logic [127:0] q;
    for (int k = 0; k < 4; k++) q[32*k +: 32] = 32'hC0DE_0000 + 32'(addr + k);
    return q;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit iv, input logic [127:0] iq, input bit ordy,
                       input logic [1:0] so, input bit fl);
    @(negedge clk);
    in_valid = iv; in_quad = iq; out_ready = ordy; start_ofs = so; flush = fl;
    #1;
  endtask

  task automatic do_flush();
    drive(1'b0, '0, 1'b1, 2'd0, 1'b1);
    chk(!out_valid && !in_ready, "R8", "flush gates handshakes",
        {out_valid, in_ready}, 0);
    drive(1'b0, '0, 1'b1, 2'd0, 1'b0);
    chk(!out_valid, "R8", "empty after flush", out_valid, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!out_valid && in_ready, "R1", "in reset", {out_valid, in_ready}, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R1", "after reset", {out_valid, in_ready}, 1);
  endtask

  task automatic run_stream(input int o, input int o_later, input int nb,
                            input int base, input string req);
    int pushed = 0, popped = 0, cyc = 0, stalls = 0, gaps = 0;
    int exp_out = (o == 0) ? nb : nb - 1;
    bit started = 1'b0;
    do_flush();
    while ((pushed < nb || popped < exp_out) && cyc < nb + 20) begin
      drive(pushed < nb, mk(base + 4*pushed), 1'b1,
            2'(pushed == 0 ? o : o_later), 1'b0);
      if (out_valid) begin
        chk(out_quad == mk(base + o + 4*popped), req, "merged data",
            out_quad, mk(base + o + 4*popped));
        popped++;
        started = 1'b1;
      end else if (started && popped < exp_out) gaps++;
      if (in_valid && in_ready) pushed++;
      else if (in_valid) stalls++;
      cyc++;
    end
    drive(1'b0, '0, 1'b1, 2'd0, 1'b0);
    chk(!out_valid, req, "no extra output", out_valid, 0);
    chk(popped == exp_out, "R6", "output count", 128'(popped), 128'(exp_out));
    chk(stalls == 0 && gaps == 0, "R6", "stalls/gaps", 128'(stalls + gaps), 0);
  endtask

  task automatic t_latency();
    do_flush();
    drive(1'b1, mk(200), 1'b0, 2'd0, 1'b0);
    chk(!out_valid, "R3", "not valid before accept", out_valid, 0);
    drive(1'b0, '0, 1'b0, 2'd0, 1'b0);
    chk(out_valid && out_quad == mk(200), "R2/R3", "passthrough", out_quad, mk(200));
    do_flush();
    drive(1'b1, mk(300), 1'b0, 2'd3, 1'b0);
    drive(1'b1, mk(304), 1'b0, 2'd3, 1'b0);
    chk(!out_valid, "R4", "one entry only", out_valid, 0);
    drive(1'b0, '0, 1'b0, 2'd3, 1'b0);
    chk(out_valid && out_quad == mk(303), "R2/R4", "first merge", out_quad, mk(303));
  endtask

  task automatic t_backpressure();
    logic [127:0] held;
    do_flush();
    drive(1'b1, mk(100), 1'b0, 2'd2, 1'b0);
    drive(1'b1, mk(104), 1'b0, 2'd2, 1'b0);
    drive(1'b1, mk(108), 1'b0, 2'd2, 1'b0);
    chk(out_valid && !in_ready, "R7", "full, input blocked",
        {out_valid, in_ready}, 2);
    held = out_quad;
    chk(held == mk(102), "R4", "merge ofs 2", held, mk(102));
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, mk(108), 1'b0, 2'd2, 1'b0);
      chk(out_valid && out_quad == held && !in_ready, "R7", "held stable",
          out_quad, held);
    end
    drive(1'b1, mk(108), 1'b1, 2'd2, 1'b0);
    chk(out_valid && in_ready && out_quad == mk(102), "R7", "release",
        out_quad, mk(102));
    drive(1'b0, '0, 1'b1, 2'd2, 1'b0);
    chk(out_valid && out_quad == mk(106), "R7", "after release", out_quad, mk(106));
    drive(1'b0, '0, 1'b1, 2'd2, 1'b0);
    chk(!out_valid, "R7", "leftover not emitted", out_valid, 0);
  endtask

  task automatic t_flush_mid();
    do_flush();
    drive(1'b1, mk(400), 1'b0, 2'd1, 1'b0);
    drive(1'b1, mk(404), 1'b0, 2'd1, 1'b0);
    drive(1'b1, mk(900), 1'b1, 2'd1, 1'b1);
    chk(!out_valid && !in_ready, "R8", "flush with beat offered",
        {out_valid, in_ready}, 0);
    drive(1'b0, '0, 1'b1, 2'd1, 1'b0);
    chk(!out_valid, "R8", "entries dropped", out_valid, 0);
    drive(1'b1, mk(500), 1'b0, 2'd0, 1'b0);
    drive(1'b0, '0, 1'b0, 2'd0, 1'b0);
    chk(out_valid && out_quad == mk(500), "R8", "new offset after flush",
        out_quad, mk(500));
  endtask

  initial begin
    t_reset();
    t_latency();
    run_stream(0, 0, 6, 0, "R3");
    run_stream(1, 1, 6, 1000, "R4");
    run_stream(2, 2, 5, 2000, "R4");
    run_stream(3, 3, 7, 3000, "R4");
    run_stream(1, 3, 5, 4000, "R5");
    run_stream(0, 2, 4, 5000, "R5");
    t_backpressure();
    t_flush_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule